// File: doc/BRIEF.md
# Receive Frame Drop Filter

This block sits beside a receive FIFO and decides, once per received frame, whether the frame just written is kept for forwarding or thrown away. The MAC receive path presents the frame's end-of-frame status. That status covers the error flags, the runt and partial-overflow indications, the frame length in bytes, and a flag telling whether the start of the frame has already been passed to the read side because of threshold-mode forwarding. One cycle after accepting that status, the filter pulses either `commit` or `discard`.

The filter also keeps the saved start-of-frame pointer of the FIFO. On a commit it advances that pointer to the write pointer sampled with the status, so that the next frame starts there. On a discard the pointer is left alone and serves as the rewind target: the FIFO write side reloads its write pointer from `sof_ptr` and the frame's bytes are lost. Three configuration bits and a giant-length limit select the policy: forward error frames, forward short good frames, and drop oversized frames.

The status input follows a valid/ready handshake. `st_ready` is low during reset and in the first cycle after it, and high from then on, so status can be accepted every cycle. A status beat is taken on a rising edge where `st_valid` and `st_ready` are both high. The status fields need to be stable only in that cycle.

Top module: `rx_drop_filter`

## Requirements
- R1: A frame whose `st_early` flag is 1 (its start is already with the read side) is always committed, whatever its error, runt, size or overflow flags say.
- R2: A frame that is not early and has `st_runt` = 1 is always discarded, even when `cfg_fwd_err` = 1.
- R3: A frame that is not early and has `st_ovf_partial` = 1 (the FIFO overflowed mid-frame) is discarded, even when `cfg_fwd_err` = 1.
- R4: With `cfg_fwd_err` = 0, a frame that is not early and has any of `st_crc_err`, `st_coll`, `st_giant`, `st_wdt` or `st_ovf` set is discarded.
- R5: With `cfg_fwd_err` = 1, a frame with those error flags, and no runt or partial-overflow flag, is committed, provided that the size rules of R7 do not drop it.
- R6: An error-free frame that is not early and has `st_len` < 64 is discarded when `cfg_fwd_small` = 0 and committed when it is 1. A frame of exactly 64 bytes is never treated as short.
- R7: With `cfg_drop_giant` = 1, a frame that is not early and has `st_len` > `cfg_giant_limit` is discarded. `st_len` equal to the limit is kept. With `cfg_drop_giant` = 0, length never causes a drop.
- R8: For each accepted status beat, exactly one of `commit` and `discard` is high, for one cycle, in the cycle after acceptance. Otherwise both are low.
- R9: After a commit, `sof_ptr` holds the `wr_ptr` value sampled with that frame's status, from the cycle after the commit pulse. A discard leaves `sof_ptr` unchanged.
- R10: During reset `commit` and `discard` are 0, `sof_ptr` is 0 and `st_ready` is 0. After reset `st_ready` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fwd_err | input | 1 | Keep frames carrying error status (runt and partial overflow excepted) |
| cfg_fwd_small | input | 1 | Keep error-free frames shorter than the minimum length |
| cfg_drop_giant | input | 1 | Drop frames longer than `cfg_giant_limit` |
| cfg_giant_limit | input | LEN_W | Largest length not counted as giant |
| st_valid | input | 1 | End-of-frame status valid |
| st_ready | output | 1 | Filter can take status |
| st_crc_err | input | 1 | CRC error |
| st_coll | input | 1 | Collision seen |
| st_giant | input | 1 | Giant-frame status from the MAC |
| st_wdt | input | 1 | Receive watchdog timeout |
| st_ovf | input | 1 | Overflow status |
| st_ovf_partial | input | 1 | FIFO overflowed while this frame was partly written |
| st_runt | input | 1 | Runt frame |
| st_early | input | 1 | Frame start already handed to the read side |
| st_len | input | LEN_W | Frame length in bytes, pad and CRC included |
| wr_ptr | input | PTR_W | Current FIFO write pointer, sampled with the status |
| commit | output | 1 | Frame kept, one-cycle pulse |
| discard | output | 1 | Frame dropped, rewind to `sof_ptr`, one-cycle pulse |
| sof_ptr | output | PTR_W | Saved start-of-frame pointer |

## Verification
The bench builds the filter with LEN_W = 14, MIN_LEN = 64 and PTR_W = 6. A 14-bit length brings the top of the giant-limit range (16383) within reach, so the limit-equal and limit-plus-one cases can be tried both at a small limit and at the maximum. A 6-bit pointer makes the modelled write pointer wrap within a few frames, so the `sof_ptr` check after each commit or discard also covers wrapped values. Frames are sent back to back as well as spaced apart, which shows that one decision pulse follows each beat with no gaps.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;

  typedef struct packed {
    logic crc_err;
    logic coll;
    logic giant;
    logic wdt;
    logic ovf;
    logic ovf_partial;
    logic runt;
    logic early;
  } rx_flags_t;

  typedef enum logic [2:0] {
    VERDICT_KEEP_EARLY,
    VERDICT_DROP_RUNT,
    VERDICT_DROP_PARTIAL,
    VERDICT_DROP_ERROR,
    VERDICT_DROP_GIANT,
    VERDICT_DROP_SHORT,
    VERDICT_KEEP
  } verdict_e;

  function automatic logic verdict_is_keep(verdict_e v);
    return (v == VERDICT_KEEP_EARLY) || (v == VERDICT_KEEP);
  endfunction

endpackage

// File: rtl/rxdf_classify.sv
module rxdf_classify
  import rxdf_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64
) (
  input  rx_flags_t        flags,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] giant_limit,
  output logic             has_error,
  output logic             is_short,
  output logic             is_long
);
  localparam int ERR_N = 5;
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  logic [ERR_N-1:0] err_vec;

  assign err_vec   = {flags.crc_err, flags.coll, flags.giant, flags.wdt, flags.ovf};
  assign has_error = |err_vec;
  // short only counts for frames with no error of any kind
  assign is_short  = !has_error && !flags.runt && (len < MIN_LEN_V);
  assign is_long   = (len > giant_limit);
endmodule

// File: rtl/rxdf_policy.sv
module rxdf_policy
  import rxdf_pkg::*;
(
  input  rx_flags_t flags,
  input  logic      has_error,
  input  logic      is_short,
  input  logic      is_long,
  input  logic      fwd_err,
  input  logic      fwd_small,
  input  logic      drop_giant,
  output verdict_e  verdict
);
  always_comb begin
    if (flags.early)                  verdict = VERDICT_KEEP_EARLY;
    else if (flags.runt)              verdict = VERDICT_DROP_RUNT;
    else if (flags.ovf_partial)       verdict = VERDICT_DROP_PARTIAL;
    else if (has_error && !fwd_err)   verdict = VERDICT_DROP_ERROR;
    else if (drop_giant && is_long)   verdict = VERDICT_DROP_GIANT;
    else if (is_short && !fwd_small)  verdict = VERDICT_DROP_SHORT;
    else                              verdict = VERDICT_KEEP;
  end
endmodule

// File: rtl/rxdf_sof_track.sv
module rxdf_sof_track #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [PTR_W-1:0] next_sof,
  output logic [PTR_W-1:0] sof_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sof_ptr <= '0;
    else if (advance) sof_ptr <= next_sof;
  end
endmodule

// File: rtl/rx_drop_filter.sv
module rx_drop_filter
  import rxdf_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int PTR_W   = 10,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fwd_err,
  input  logic             cfg_fwd_small,
  input  logic             cfg_drop_giant,
  input  logic [LEN_W-1:0] cfg_giant_limit,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic             st_crc_err,
  input  logic             st_coll,
  input  logic             st_giant,
  input  logic             st_wdt,
  input  logic             st_ovf,
  input  logic             st_ovf_partial,
  input  logic             st_runt,
  input  logic             st_early,
  input  logic [LEN_W-1:0] st_len,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic             commit,
  output logic             discard,
  output logic [PTR_W-1:0] sof_ptr
);
  rx_flags_t        flags;
  logic             has_error, is_short, is_long;
  verdict_e         verdict;
  logic             accept;
  logic             ready_q;
  logic             commit_q, discard_q;
  logic [PTR_W-1:0] end_ptr_q;

  assign flags = '{crc_err: st_crc_err, coll: st_coll, giant: st_giant,
                   wdt: st_wdt, ovf: st_ovf, ovf_partial: st_ovf_partial,
                   runt: st_runt, early: st_early};

  rxdf_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_classify (
    .flags       (flags),
    .len         (st_len),
    .giant_limit (cfg_giant_limit),
    .has_error   (has_error),
    .is_short    (is_short),
    .is_long     (is_long)
  );

  rxdf_policy u_policy (
    .flags      (flags),
    .has_error  (has_error),
    .is_short   (is_short),
    .is_long    (is_long),
    .fwd_err    (cfg_fwd_err),
    .fwd_small  (cfg_fwd_small),
    .drop_giant (cfg_drop_giant),
    .verdict    (verdict)
  );

  assign accept   = st_valid && ready_q;
  assign st_ready = ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      commit_q  <= 1'b0;
      discard_q <= 1'b0;
      end_ptr_q <= '0;
    end else begin
      ready_q   <= 1'b1;
      commit_q  <= accept && verdict_is_keep(verdict);
      discard_q <= accept && !verdict_is_keep(verdict);
      if (accept) end_ptr_q <= wr_ptr;
    end
  end

  rxdf_sof_track #(.PTR_W(PTR_W)) u_sof (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (commit_q),
    .next_sof (end_ptr_q),
    .sof_ptr  (sof_ptr)
  );

  assign commit  = commit_q;
  assign discard = discard_q;
endmodule

// File: rtl/rx_drop_filter_chk.sv
module rx_drop_filter_chk #(
  parameter int LEN_W = 14,
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fwd_err,
  input logic             st_valid,
  input logic             st_ready,
  input logic             st_crc_err,
  input logic             st_coll,
  input logic             st_giant,
  input logic             st_wdt,
  input logic             st_ovf,
  input logic             st_ovf_partial,
  input logic             st_runt,
  input logic             st_early,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             commit,
  input logic             discard,
  input logic [PTR_W-1:0] sof_ptr
);
  logic fire, errs;
  assign fire = st_valid && st_ready;
  assign errs = st_crc_err || st_coll || st_giant || st_wdt || st_ovf;

  assert_early_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && st_early |=> commit);
  assert_runt_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !st_early && st_runt |=> discard);
  assert_partial_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !st_early && st_ovf_partial |=> discard);
  assert_error_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !st_early && errs && !cfg_fwd_err |=> discard);
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && discard));
  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (commit || discard));
  assert_no_idle_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !(commit || discard));
  assert_sof_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> sof_ptr == $past(wr_ptr, 2));
  assert_sof_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> $stable(sof_ptr));
endmodule

bind rx_drop_filter rx_drop_filter_chk #(.LEN_W(LEN_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fwd_err(cfg_fwd_err),
  .st_valid(st_valid), .st_ready(st_ready),
  .st_crc_err(st_crc_err), .st_coll(st_coll), .st_giant(st_giant),
  .st_wdt(st_wdt), .st_ovf(st_ovf), .st_ovf_partial(st_ovf_partial),
  .st_runt(st_runt), .st_early(st_early), .wr_ptr(wr_ptr),
  .commit(commit), .discard(discard), .sof_ptr(sof_ptr)
);

// File: tb/rx_drop_filter_bench.sv
module rx_drop_filter_bench;
  localparam int LEN_W = 14;
  localparam int PTR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fwd_err = 0, cfg_fwd_small = 0, cfg_drop_giant = 0;
  logic [LEN_W-1:0] cfg_giant_limit = 14'd1518;
  logic st_valid = 0;
  logic st_ready;
  logic st_crc_err = 0, st_coll = 0, st_giant = 0, st_wdt = 0, st_ovf = 0;
  logic st_ovf_partial = 0, st_runt = 0, st_early = 0;
  logic [LEN_W-1:0] st_len = 14'd100;
  logic [PTR_W-1:0] wr_ptr = '0;
  logic commit, discard;
  logic [PTR_W-1:0] sof_ptr;

  int checks = 0;
  int errors = 0;
  logic [PTR_W-1:0] exp_sof = '0;

  always #5 clk = ~clk;

  rx_drop_filter #(.LEN_W(LEN_W), .PTR_W(PTR_W), .MIN_LEN(64)) u_rx_drop_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_fwd_err(cfg_fwd_err), .cfg_fwd_small(cfg_fwd_small),
    .cfg_drop_giant(cfg_drop_giant), .cfg_giant_limit(cfg_giant_limit),
    .st_valid(st_valid), .st_ready(st_ready),
    .st_crc_err(st_crc_err), .st_coll(st_coll), .st_giant(st_giant),
    .st_wdt(st_wdt), .st_ovf(st_ovf), .st_ovf_partial(st_ovf_partial),
    .st_runt(st_runt), .st_early(st_early), .st_len(st_len),
    .wr_ptr(wr_ptr), .commit(commit), .discard(discard), .sof_ptr(sof_ptr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    st_crc_err = 0; st_coll = 0; st_giant = 0; st_wdt = 0; st_ovf = 0;
    st_ovf_partial = 0; st_runt = 0; st_early = 0;
  endtask

  // one frame: drive at negedge, see strobe after next edge, sof one edge later
  task automatic run_frame(input logic keep, input string req);
    @(negedge clk);
    wr_ptr   = wr_ptr + PTR_W'(st_len);
    st_valid = 1;
    @(negedge clk);
    st_valid = 0;
    check(req, {30'd0, commit, discard}, keep ? 32'd2 : 32'd1);
    if (keep) exp_sof = wr_ptr;
    @(negedge clk);
    check("R9", sof_ptr, exp_sof);
    check("R8", {30'd0, commit, discard}, 32'd0);
    clear_flags();
  endtask

  task automatic t_reset();
    check("R10", {29'd0, st_ready, commit, discard}, 32'd0);
    check("R10", sof_ptr, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);
    check("R10", st_ready, 1);
  endtask

  task automatic t_early();
    cfg_fwd_err = 0; cfg_drop_giant = 1; cfg_giant_limit = 14'd100;
    st_early = 1; st_crc_err = 1; st_runt = 1; st_ovf_partial = 1; st_len = 14'd500;
    run_frame(1, "R1");
    st_early = 1; st_len = 14'd20;
    run_frame(1, "R1");
    cfg_drop_giant = 0; cfg_giant_limit = 14'd1518;
  endtask

  task automatic t_runt_partial();
    cfg_fwd_err = 1; cfg_fwd_small = 1;
    st_runt = 1; st_len = 14'd30;
    run_frame(0, "R2");
    st_ovf_partial = 1; st_len = 14'd200;
    run_frame(0, "R3");
    cfg_fwd_small = 0;
  endtask

  task automatic t_errors();
    cfg_fwd_err = 0; st_len = 14'd200;
    st_crc_err = 1; run_frame(0, "R4");
    st_coll = 1;    run_frame(0, "R4");
    st_giant = 1;   run_frame(0, "R4");
    st_wdt = 1;     run_frame(0, "R4");
    st_ovf = 1;     run_frame(0, "R4");
    cfg_fwd_err = 1;
    st_crc_err = 1; run_frame(1, "R5");
    st_wdt = 1; st_ovf = 1; run_frame(1, "R5");
    st_coll = 1; st_len = 14'd40; run_frame(1, "R5");
    cfg_fwd_err = 0;
  endtask

  task automatic t_short();
    cfg_fwd_small = 0;
    st_len = 14'd63; run_frame(0, "R6");
    st_len = 14'd64; run_frame(1, "R6");
    cfg_fwd_small = 1;
    st_len = 14'd63; run_frame(1, "R6");
    cfg_fwd_small = 0;
  endtask

  task automatic t_giant();
    cfg_drop_giant = 1; cfg_giant_limit = 14'd1518;
    st_len = 14'd1519; run_frame(0, "R7");
    st_len = 14'd1518; run_frame(1, "R7");
    cfg_giant_limit = 14'd16383;
    st_len = 14'd16383; run_frame(1, "R7");
    cfg_giant_limit = 14'd16382; run_frame(0, "R7");
    cfg_drop_giant = 0; run_frame(1, "R7");
    cfg_giant_limit = 14'd1518;
  endtask

  task automatic t_back_to_back();
    // two beats in consecutive cycles: keep then drop
    @(negedge clk);
    st_len = 14'd100; wr_ptr = wr_ptr + 6'd5; st_valid = 1;
    @(negedge clk);
    check("R8", {30'd0, commit, discard}, 32'd2);
    exp_sof = wr_ptr;
    st_runt = 1; wr_ptr = wr_ptr + 6'd9;
    @(negedge clk);
    st_valid = 0;
    check("R8", {30'd0, commit, discard}, 32'd1);
    check("R9", sof_ptr, exp_sof);
    @(negedge clk);
    check("R9", sof_ptr, exp_sof);
    check("R8", {30'd0, commit, discard}, 32'd0);
    clear_flags();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_early();
    t_runt_partial();
    t_errors();
    t_short();
    t_giant();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule